// File: doc/BRIEF.md
# Scanline-Count Interrupt Generator

This block raises a level interrupt request after the CPU-programmed number of visible scanlines has gone by. The CPU writes an 8-bit count to the load address. A video timing source sends one pulse per scanline, together with that line's number and a flag that says whether rendering is on. Each qualifying pulse takes one from the count. When the count steps from one to zero, the interrupt is latched and the line stays asserted.

The CPU clears the request by writing to a separate acknowledge address. That write leaves the count alone. The count never reloads by itself, so after it fires the block stays quiet until software writes a new count. Write data to the acknowledge address is ignored.

Top module: `scanline_irq_gen`

## Requirements
- R1: After a synchronous active-low reset, `irq` is 0 and the count is 0, so later scanline pulses raise nothing until a count is written.
- R2: A write with `cpu_addr` equal to 16'hE003 loads the count from `cpu_data`. Writes to any other address (e.g. 16'hE001, 16'hE013) leave the count unchanged.
- R3: A write with `cpu_addr` equal to exactly 16'hE002 drops `irq` to 0 on the next cycle and leaves the count unchanged. A write to 16'hF002 does not acknowledge.
- R4: A pulse on `line_pulse` decrements the count only when `line_num` is in 0..239 and `render_on` is 1. Pulses on lines 240 and above, and pulses while rendering is off, have no effect.
- R5: A count of zero is never decremented and never raises `irq`.
- R6: A qualifying pulse that takes the count from 1 to 0 sets `irq` to 1 in the cycle after the pulse.
- R7: After it fires, the count stays at zero. No further interrupt occurs until a new count is loaded, even after an acknowledge.
- R8: `irq` holds at 1 through idle cycles and through later pulses until an acknowledge write.
- R9: When a load or acknowledge write falls in the same cycle as a qualifying pulse, the write takes effect and that pulse is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU write address |
| cpu_data | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe, one cycle per write |
| line_pulse | input | 1 | One-cycle pulse per scanline |
| line_num | input | 9 | Number of the line carried by the pulse |
| render_on | input | 1 | Rendering enabled |
| irq | output | 1 | Level interrupt request, active high |

## Verification
The hardest case to reach is a CPU write and a scanline pulse that land on the same clock edge while the count is one. The bench drives both in one cycle from a single task, for both the load and the acknowledge write. It then confirms that no interrupt appears and that the following pulse fires at the point the write predicts. Because the count is not visible at the ports, each case works it out from when `irq` rises after a known series of pulses.

// File: rtl/scanline_irq_pkg.sv
// Package: shared types for the scanline interrupt generator.
// Assumes one CPU write at most per cycle.
package scanline_irq_pkg;
    // Decoded CPU register access
    typedef enum logic [1:0] {
        SIRQ_CMD_NONE = 2'd0,
        SIRQ_CMD_LOAD = 2'd1,
        SIRQ_CMD_ACK  = 2'd2
    } sirq_cmd_t;
endpackage

// File: rtl/sirq_bus_decode.sv
// Module: sirq_bus_decode
// Turns a CPU write into a load or acknowledge command by full address match.
// Assumes cpu_we is a single-cycle strobe. Other addresses give no command.
module sirq_bus_decode
    import scanline_irq_pkg::*;
#(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] LOAD_ADDR = 16'hE003,
    parameter logic [15:0] ACK_ADDR  = 16'hE002
) (
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    output sirq_cmd_t         cmd
);
    localparam logic [ADDR_W-1:0] LOAD_MATCH = ADDR_W'(LOAD_ADDR);
    localparam logic [ADDR_W-1:0] ACK_MATCH  = ADDR_W'(ACK_ADDR);

    // Purpose: full-width compare against each register address
    always_comb begin
        cmd = SIRQ_CMD_NONE;
        if (cpu_we) begin
            if (cpu_addr == LOAD_MATCH)
                cmd = SIRQ_CMD_LOAD;
            else if (cpu_addr == ACK_MATCH)
                cmd = SIRQ_CMD_ACK;
        end
    end
endmodule

// File: rtl/sirq_line_qualify.sv
// Module: sirq_line_qualify
// Passes a scanline pulse on as a count tick when the line is visible and
// rendering is on. Assumes line numbers are unsigned and start at zero.
module sirq_line_qualify #(
    parameter int LINE_W       = 9,
    parameter int LAST_VISIBLE = 239
) (
    input  logic              line_pulse,
    input  logic [LINE_W-1:0] line_num,
    input  logic              render_on,
    output logic              tick
);
    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LAST_VISIBLE);

    // Purpose: gate the pulse by the visible range and the render flag
    always_comb begin
        tick = line_pulse && render_on && (line_num <= LAST_LINE);
    end
endmodule

// File: rtl/sirq_down_counter.sv
// Module: sirq_down_counter
// Holds the count and the pending flag. A load or acknowledge command wins
// over a tick in the same cycle. A tick on a zero count does nothing. The
// pending flag sets when a tick takes the count from 1 to 0.
module sirq_down_counter
    import scanline_irq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  sirq_cmd_t        cmd,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic [CNT_W-1:0] cnt,
    output logic             pending
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Purpose: count register and pending flag, with CPU commands first
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            pending <= 1'b0;
        end else begin
            unique case (cmd)
                SIRQ_CMD_LOAD: cnt <= load_val;
                SIRQ_CMD_ACK:  pending <= 1'b0;
                default: begin
                    if (tick && (cnt != '0)) begin
                        cnt <= cnt - ONE;
                        if (cnt == ONE)
                            pending <= 1'b1;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/scanline_irq_gen.sv
// Module: scanline_irq_gen (top)
// Counts visible scanlines down from a CPU-loaded value and holds a level
// IRQ once the count runs out. Assumes all inputs are synchronous to clk.
module scanline_irq_gen
    import scanline_irq_pkg::*;
#(
    parameter int          ADDR_W       = 16,
    parameter int          DATA_W       = 8,
    parameter int          LINE_W       = 9,
    parameter int          LAST_VISIBLE = 239,
    parameter logic [15:0] LOAD_ADDR    = 16'hE003,
    parameter logic [15:0] ACK_ADDR     = 16'hE002
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_data,
    input  logic              cpu_we,
    input  logic              line_pulse,
    input  logic [LINE_W-1:0] line_num,
    input  logic              render_on,
    output logic              irq
);
    sirq_cmd_t         cmd;
    logic              tick;
    logic [DATA_W-1:0] cnt_q;
    logic              pending_q;

    sirq_bus_decode #(
        .ADDR_W    (ADDR_W),
        .LOAD_ADDR (LOAD_ADDR),
        .ACK_ADDR  (ACK_ADDR)
    ) u_decode (
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cmd      (cmd)
    );

    sirq_line_qualify #(
        .LINE_W       (LINE_W),
        .LAST_VISIBLE (LAST_VISIBLE)
    ) u_qualify (
        .line_pulse (line_pulse),
        .line_num   (line_num),
        .render_on  (render_on),
        .tick       (tick)
    );

    sirq_down_counter #(
        .CNT_W (DATA_W)
    ) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd      (cmd),
        .load_val (cpu_data),
        .tick     (tick),
        .cnt      (cnt_q),
        .pending  (pending_q)
    );

    // Purpose: drive the IRQ line straight from the pending register
    always_comb irq = pending_q;
endmodule

// File: rtl/sirq_checker.sv
// Module: sirq_checker
// Assertions for scanline_irq_gen, attached with bind. It recomputes address
// matches and line qualification from the ports.
module sirq_checker #(
    parameter int          ADDR_W       = 16,
    parameter int          DATA_W       = 8,
    parameter int          LINE_W       = 9,
    parameter int          LAST_VISIBLE = 239,
    parameter logic [15:0] LOAD_ADDR    = 16'hE003,
    parameter logic [15:0] ACK_ADDR     = 16'hE002
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DATA_W-1:0] cpu_data,
    input logic              cpu_we,
    input logic              line_pulse,
    input logic [LINE_W-1:0] line_num,
    input logic              render_on,
    input logic              irq,
    input logic [DATA_W-1:0] cnt_q
);
    logic is_load, is_ack, visible;
    always_comb begin
        is_load = cpu_we && (cpu_addr == ADDR_W'(LOAD_ADDR));
        is_ack  = cpu_we && (cpu_addr == ADDR_W'(ACK_ADDR));
        visible = line_pulse && render_on && (line_num <= LINE_W'(LAST_VISIBLE));
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!irq && cnt_q == '0));

    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        is_load |=> cnt_q == $past(cpu_data));

    assert_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
        is_ack |=> (!irq && cnt_q == $past(cnt_q)));

    assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!visible && !is_load) |=> cnt_q == $past(cnt_q));

    assert_zero_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !is_load) |=> cnt_q == '0);

    assert_fire_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (visible && cnt_q == DATA_W'(1) && !is_load && !is_ack) |=> (irq && cnt_q == '0));

    assert_no_refire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && cnt_q == '0) |=> !irq);

    assert_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !is_ack) |=> irq);

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (visible && is_ack) |=> cnt_q == $past(cnt_q));
endmodule

bind scanline_irq_gen sirq_checker #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .LINE_W       (LINE_W),
    .LAST_VISIBLE (LAST_VISIBLE),
    .LOAD_ADDR    (LOAD_ADDR),
    .ACK_ADDR     (ACK_ADDR)
) u_sirq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_addr   (cpu_addr),
    .cpu_data   (cpu_data),
    .cpu_we     (cpu_we),
    .line_pulse (line_pulse),
    .line_num   (line_num),
    .render_on  (render_on),
    .irq        (irq),
    .cnt_q      (cnt_q)
);

// File: tb/scanline_irq_gen_bench.sv
// Bench: scanline_irq_gen_bench
// Directed scenarios, one task each. Inputs change on the falling edge and
// irq is sampled on the falling edge after the capturing rising edge.
module scanline_irq_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_we = 1'b0;
    logic        line_pulse = 1'b0;
    logic [8:0]  line_num = '0;
    logic        render_on = 1'b1;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;  // 125 MHz

    scanline_irq_gen u_scanline_irq_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_addr   (cpu_addr),
        .cpu_data   (cpu_data),
        .cpu_we     (cpu_we),
        .line_pulse (line_pulse),
        .line_num   (line_num),
        .render_on  (render_on),
        .irq        (irq)
    );

    task automatic check(input logic actual, input logic expected, input string req, input string what);
        n_tests++;
        if (actual !== expected) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, actual, expected);
        end
    endtask

    // One cycle holding the given stimulus; returns at the next falling edge
    task automatic cycle(input logic we, input logic [15:0] a, input logic [7:0] d,
                         input logic lp, input logic [8:0] ln, input logic ren);
        cpu_we = we; cpu_addr = a; cpu_data = d;
        line_pulse = lp; line_num = ln; render_on = ren;
        @(negedge clk);
        cpu_we = 1'b0; line_pulse = 1'b0; render_on = 1'b1;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        cycle(1'b1, a, d, 1'b0, 9'd0, 1'b1);
    endtask

    task automatic line(input logic [8:0] ln, input logic ren);
        cycle(1'b0, 16'h0000, 8'h00, 1'b1, ln, ren);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(irq, 1'b0, "R1", "irq after reset");
        for (int i = 0; i < 3; i++) line(9'(i), 1'b1);
        check(irq, 1'b0, "R1", "pulses after reset raise nothing");
    endtask

    task automatic t_basic();
        do_reset();
        wr(16'hE003, 8'd3);
        line(9'd10, 1'b1);
        check(irq, 1'b0, "R2", "count 3 after one line");
        line(9'd11, 1'b1);
        check(irq, 1'b0, "R6", "count 3 after two lines");
        line(9'd12, 1'b1);
        check(irq, 1'b1, "R6", "fires on 1->0");
        for (int i = 0; i < 4; i++) @(negedge clk);
        line(9'd20, 1'b1);
        check(irq, 1'b1, "R8", "irq holds until ack");
        wr(16'hE002, 8'hFF);
        check(irq, 1'b0, "R3", "ack clears irq");
        for (int i = 0; i < 300; i++) line(9'(i % 240), 1'b1);
        check(irq, 1'b0, "R7", "no refire after expiry");
    endtask

    task automatic t_ack_keeps_count();
        do_reset();
        wr(16'hE003, 8'd4);
        line(9'd0, 1'b1);
        wr(16'hE002, 8'h00);
        line(9'd1, 1'b1);
        line(9'd2, 1'b1);
        check(irq, 1'b0, "R3", "count kept across ack (not yet)");
        line(9'd3, 1'b1);
        check(irq, 1'b1, "R3", "count kept across ack (fires)");
    endtask

    task automatic t_gating();
        do_reset();
        wr(16'hE003, 8'd2);
        line(9'd240, 1'b1);
        line(9'd261, 1'b1);
        line(9'd10, 1'b0);
        line(9'd239, 1'b1);
        check(irq, 1'b0, "R4", "only line 239 counted");
        line(9'd0, 1'b1);
        check(irq, 1'b1, "R4", "line 0 counted, fires");
    endtask

    task automatic t_addr_exact();
        do_reset();
        wr(16'hE003, 8'd1);
        wr(16'hE001, 8'd5);
        wr(16'hE013, 8'd5);
        wr(16'h6003, 8'd5);
        line(9'd5, 1'b1);
        check(irq, 1'b1, "R2", "other addresses do not load");
        wr(16'hF002, 8'd0);
        check(irq, 1'b1, "R3", "F002 is not an ack");
        wr(16'hE002, 8'd0);
        check(irq, 1'b0, "R3", "E002 acks");
    endtask

    task automatic t_zero();
        do_reset();
        wr(16'hE003, 8'd0);
        for (int i = 0; i < 260; i++) line(9'(i % 240), 1'b1);
        check(irq, 1'b0, "R5", "zero count never fires");
    endtask

    task automatic t_priority();
        do_reset();
        wr(16'hE003, 8'd1);
        cycle(1'b1, 16'hE003, 8'd2, 1'b1, 9'd7, 1'b1);
        check(irq, 1'b0, "R9", "load beats pulse");
        line(9'd8, 1'b1);
        check(irq, 1'b0, "R9", "reloaded 2 needs two lines");
        line(9'd9, 1'b1);
        check(irq, 1'b1, "R9", "reloaded 2 fires on second line");
        wr(16'hE002, 8'd0);
        wr(16'hE003, 8'd1);
        cycle(1'b1, 16'hE002, 8'd0, 1'b1, 9'd30, 1'b1);
        check(irq, 1'b0, "R9", "ack beats pulse, no fire");
        line(9'd31, 1'b1);
        check(irq, 1'b1, "R9", "count still 1 after ack+pulse");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_ack_keeps_count();
        t_gating();
        t_addr_exact();
        t_zero();
        t_priority();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule